// File: doc/BRIEF.md
# Dual-Path Fractional Baud Rate Generator

This block derives the bit-rate timing of a serial port from the system clock. A reloadable down-counter sets the bit period. It advances on enable pulses from one of two selectable prescalers. The first is a fixed divider that passes every second or every third clock. The second is a fractional accumulator that passes `ratio/512` of the clock edges. It serves baud rates that no integer divider can reach.

Each counter underflow produces a one-cycle oversampling tick for a UART receiver. Every `OSR` oversampling ticks, a baud tick for the transmitter is issued in the same cycle. A wrapping count of baud ticks lets a testbench measure the effective rate over a window.

When the run input is cleared, every stage returns to a fixed starting point. Because of this, each start of the generator produces the same tick pattern.

Top module: `baud_rate_gen`

## Requirements
- R1: While `run` is low, `os_tick` and `baud_tick` stay low and `tick_count` keeps its value.
- R2: With `frac_sel` low, the timer receives one enable every 2 clocks when `div3_sel` is 0 and every 3 clocks when `div3_sel` is 1. Counting from the first edge that samples `run` high, the enables land on edges `2k` or `3k`.
- R3: The timer underflows once every `reload+1` enables. Each underflow raises `os_tick` for exactly one cycle, starting after the edge that carries the underflowing enable.
- R4: With `frac_sel` high, a 9-bit accumulator adds `ratio` on every running clock and gives one enable per carry. By edge `c` the timer has therefore received `floor(c*ratio/512)` enables. A `ratio` of 0 gives no enables at all.
- R5: `frac_sel` chooses the enable source. At 1 the fractional path drives the timer and the fixed divider is held idle. At 0 the fixed divider drives the timer.
- R6: Every `OSR`-th `os_tick` after a start also raises `baud_tick` in the same cycle. `baud_tick` is never high without `os_tick`.
- R7: A new `reload` value applied while running leaves the current period unchanged. It is loaded at the next underflow.
- R8: Clearing `run` resets the prescalers and the accumulator to zero, loads `reload` into the timer and clears the oversampling count. After a restart, the first `os_tick` therefore follows edge `(reload+1)*div` on the fixed path, or edge `ceil((reload+1)*512/ratio)` on the fractional path.
- R9: `tick_count` rises by one, modulo `2^CNT_W`, in the same cycle as each `baud_tick`. Only reset clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run | input | 1 | Generator run enable |
| div3_sel | input | 1 | Fixed prescaler: 1 divides by 3, 0 by 2 |
| frac_sel | input | 1 | 1 selects the fractional divider as the timer source |
| reload | input | RELOAD_W | Timer reload value |
| ratio | input | FRAC_W | Fractional step added per clock |
| os_tick | output | 1 | Oversampling tick, one cycle per underflow |
| baud_tick | output | 1 | Bit tick, every OSR-th oversampling tick |
| tick_count | output | CNT_W | Wrapping count of baud ticks |

## Verification
On every cycle, the tick outputs are compared with the enable count that R2 or R4 predict. The fixed path is run with both divisors and with a reload of zero, which tells a dropped or extra enable apart from an off-by-one in the timer. The fractional path is run with ratios of 511, 256, 171 and 0, plus random ratios. These separate a carry that is lost or doubled from a correct uneven spacing, and the zero ratio shows that nothing leaks through. Directed cases cover a reload change in mid-period, a long idle spell, a restart that must repeat the first pattern, and enough baud ticks to wrap the counter.

// File: rtl/brg_pkg.sv
package brg_pkg;

    typedef enum logic {
        SRC_FIXED = 1'b0,
        SRC_FRAC  = 1'b1
    } brg_src_e;

    localparam int unsigned ACC_FRAC_W_DEF = 9;
    localparam int unsigned RELOAD_W_DEF   = 13;

endpackage

// File: rtl/brg_fixed_presc.sv
module brg_fixed_presc (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic div3,
    output logic en
);

    typedef struct packed {
        logic [1:0] cnt;
    } presc_state_t;

    presc_state_t st_d, st_q;
    logic [1:0]   last;

    always_comb begin
        st_d = st_q;
        last = div3 ? 2'd2 : 2'd1;
        en   = active && (st_q.cnt == last);
        if (!active)  st_d.cnt = 2'd0;
        else if (en)  st_d.cnt = 2'd0;
        else          st_d.cnt = st_q.cnt + 2'd1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2: two enables never fall on neighbouring edges
    a_r2_en_spaced: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> !en);

    // R8: an idle divider restarts from zero
    a_r8_presc_restart: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (st_q.cnt == 2'd0));

endmodule

// File: rtl/brg_frac_div.sv
module brg_frac_div #(
    parameter int unsigned FRAC_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic [FRAC_W-1:0] ratio,
    output logic              en
);

    typedef struct packed {
        logic [FRAC_W-1:0] acc;
    } frac_state_t;

    frac_state_t       st_d, st_q;
    logic [FRAC_W:0]   sum;

    always_comb begin
        st_d = st_q;
        sum  = {1'b0, st_q.acc} + {1'b0, ratio};
        en   = active && sum[FRAC_W];
        if (active) st_d.acc = sum[FRAC_W-1:0];
        else        st_d.acc = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4: a zero step never produces a carry
    a_r4_zero_ratio: assert property (@(posedge clk) disable iff (!rst_n)
        (active && ratio == '0) |-> !en);

    // R8: the accumulator restarts from zero
    a_r8_acc_restart: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (st_q.acc == '0));

endmodule

// File: rtl/brg_reload_timer.sv
module brg_reload_timer #(
    parameter int unsigned RELOAD_W = 13,
    parameter int unsigned OSR      = 16,
    parameter int unsigned CNT_W    = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic                en,
    input  logic [RELOAD_W-1:0] reload,
    output logic                os_tick,
    output logic                baud_tick,
    output logic [CNT_W-1:0]    tick_count
);

    localparam int unsigned OS_W = (OSR > 1) ? $clog2(OSR) : 1;
    localparam logic [OS_W-1:0] OS_LAST = OS_W'(OSR - 1);

    typedef struct packed {
        logic [RELOAD_W-1:0] cnt;
        logic [OS_W-1:0]     os_cnt;
        logic                os_tick;
        logic                baud_tick;
        logic [CNT_W-1:0]    ticks;
    } tmr_state_t;

    tmr_state_t st_d, st_q;

    always_comb begin
        st_d           = st_q;
        st_d.os_tick   = 1'b0;
        st_d.baud_tick = 1'b0;
        if (!run) begin
            st_d.cnt    = reload;
            st_d.os_cnt = '0;
        end else if (en) begin
            if (st_q.cnt == '0) begin
                st_d.cnt     = reload;
                st_d.os_tick = 1'b1;
                if (st_q.os_cnt == OS_LAST) begin
                    st_d.os_cnt    = '0;
                    st_d.baud_tick = 1'b1;
                    st_d.ticks     = st_q.ticks + 1'b1;
                end else begin
                    st_d.os_cnt = st_q.os_cnt + 1'b1;
                end
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign os_tick    = st_q.os_tick;
    assign baud_tick  = st_q.baud_tick;
    assign tick_count = st_q.ticks;

    // R3 and R7: an underflow ticks and picks up the present reload input
    a_r3_underflow_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (run && en && st_q.cnt == '0) |=> (os_tick && st_q.cnt == $past(reload)));

    // R6: the bit tick only coincides with an oversampling tick
    a_r6_baud_with_os: assert property (@(posedge clk) disable iff (!rst_n)
        baud_tick |-> os_tick);

    // R9: the count steps by one alongside each bit tick
    a_r9_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        baud_tick |-> (tick_count == CNT_W'($past(tick_count) + 1'b1)));

    // R1: a stopped generator is silent and keeps its count
    a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (!os_tick && !baud_tick && $stable(tick_count)));

    // R8: stopping reloads the timer and clears the oversampling count
    a_r8_timer_restart: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (st_q.cnt == $past(reload) && st_q.os_cnt == '0));

endmodule

// File: rtl/baud_rate_gen.sv
module baud_rate_gen #(
    parameter int unsigned RELOAD_W = brg_pkg::RELOAD_W_DEF,
    parameter int unsigned FRAC_W   = brg_pkg::ACC_FRAC_W_DEF,
    parameter int unsigned OSR      = 16,
    parameter int unsigned CNT_W    = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic                div3_sel,
    input  logic                frac_sel,
    input  logic [RELOAD_W-1:0] reload,
    input  logic [FRAC_W-1:0]   ratio,
    output logic                os_tick,
    output logic                baud_tick,
    output logic [CNT_W-1:0]    tick_count
);

    import brg_pkg::*;

    brg_src_e src;
    logic     fix_active, frac_active;
    logic     fix_en, frac_en, tmr_en;

    always_comb begin
        src         = frac_sel ? SRC_FRAC : SRC_FIXED;
        fix_active  = run && (src == SRC_FIXED);
        frac_active = run && (src == SRC_FRAC);
        tmr_en      = (src == SRC_FRAC) ? frac_en : fix_en;
    end

    brg_fixed_presc u_fixed (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (fix_active),
        .div3   (div3_sel),
        .en     (fix_en)
    );

    brg_frac_div #(
        .FRAC_W (FRAC_W)
    ) u_frac (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (frac_active),
        .ratio  (ratio),
        .en     (frac_en)
    );

    brg_reload_timer #(
        .RELOAD_W (RELOAD_W),
        .OSR      (OSR),
        .CNT_W    (CNT_W)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .en         (tmr_en),
        .reload     (reload),
        .os_tick    (os_tick),
        .baud_tick  (baud_tick),
        .tick_count (tick_count)
    );

    // R5: the unselected path stays quiet
    a_r5_fixed_idle: assert property (@(posedge clk) disable iff (!rst_n)
        frac_sel |-> !fix_en);
    a_r5_frac_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !frac_sel |-> !frac_en);

endmodule

// File: tb/baud_rate_gen_test.sv
module baud_rate_gen_test;

    localparam int RW  = 13;
    localparam int FW  = 9;
    localparam int OSR = 4;
    localparam int CW  = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          run = 1'b0;
    logic          div3_sel = 1'b0;
    logic          frac_sel = 1'b0;
    logic [RW-1:0] reload = '0;
    logic [FW-1:0] ratio = '0;
    logic          os_tick, baud_tick;
    logic [CW-1:0] tick_count;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [CW-1:0] cnt_exp = '0;

    always #2 clk = ~clk;

    baud_rate_gen #(.RELOAD_W(RW), .FRAC_W(FW), .OSR(OSR), .CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .run(run), .div3_sel(div3_sel),
        .frac_sel(frac_sel), .reload(reload), .ratio(ratio),
        .os_tick(os_tick), .baud_tick(baud_tick), .tick_count(tick_count)
    );

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // enables delivered by edge c after a start (R2, R4)
    function automatic longint enables(input bit fr, input bit d3,
                                       input longint rat, input longint c);
        if (fr) return (c * rat) >> 9;
        return c / (d3 ? 3 : 2);
    endfunction

    task automatic stop_idle(input int n);
        @(negedge clk);
        run = 1'b0;
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // start with a configuration, compare outputs on every cycle, then stop
    task automatic run_cfg(input bit fr, input bit d3, input int rl,
                           input int rat, input int n, input string req);
        longint mprev, mnow;
        bit os_e, bd_e;
        @(negedge clk);
        run = 1'b0; frac_sel = fr; div3_sel = d3;
        reload = RW'(rl); ratio = FW'(rat);
        @(negedge clk);
        run = 1'b1;
        mprev = 0;
        for (int idx = 1; idx <= n; idx++) begin
            @(negedge clk);
            mnow = enables(fr, d3, rat, idx) / (rl + 1);
            os_e = (mnow > mprev);
            bd_e = os_e && (mnow % OSR == 0);
            if (bd_e) cnt_exp = cnt_exp + 1'b1;
            check({req, " os_tick"},    os_tick, os_e);
            check({req, " baud_tick"},  baud_tick, bd_e);
            check({req, " tick_count"}, tick_count, cnt_exp);
            mprev = mnow;
        end
        stop_idle(2);
    endtask

    initial begin
        #800000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd4711);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        check("R1 reset os_tick", os_tick, 0);
        check("R1 reset baud_tick", baud_tick, 0);
        check("R9 reset tick_count", tick_count, 0);

        // R2/R3 fixed path, both divisors, zero reload
        run_cfg(0, 0, 0, 0, 200, "R2 R3 div2 reload0");
        run_cfg(0, 1, 0, 0, 200, "R2 R3 div3 reload0");
        run_cfg(0, 1, 5, 0, 500, "R2 R3 div3 reload5");
        // maximum reload: no tick in a short window
        run_cfg(0, 0, 8191, 0, 100, "R3 reload max");
        // R4/R5 fractional path
        run_cfg(1, 0, 2, 511, 400, "R4 R5 ratio511");
        run_cfg(1, 1, 0, 256, 300, "R4 R5 ratio256");
        run_cfg(1, 0, 3, 171, 800, "R4 R5 ratio171");
        run_cfg(1, 1, 0, 0, 200, "R4 ratio0");
        // R8 restart gives the same pattern as the first start
        run_cfg(1, 0, 3, 171, 300, "R8 restart frac");
        run_cfg(0, 1, 5, 0, 300, "R8 restart fixed");
        // R6/R9 enough bit ticks to wrap the count
        run_cfg(0, 0, 0, 0, 700, "R6 R9 wrap");

        // random configurations
        for (int k = 0; k < 8; k++) begin
            int unsigned f, d, rl, rt;
            f  = $urandom % 2;
            d  = $urandom % 2;
            rl = $urandom % 12;
            rt = 1 + ($urandom % 511);
            run_cfg(f[0], d[0], int'(rl), int'(rt), 800, "R3 R4 R6 random");
        end

        // R1: stopped for a long spell
        @(negedge clk);
        run = 1'b0; frac_sel = 1'b1; ratio = 9'd511; reload = '0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            check("R1 stopped os_tick", os_tick, 0);
            check("R1 stopped baud_tick", baud_tick, 0);
            check("R1 stopped tick_count", tick_count, cnt_exp);
        end

        // R7: reload change in mid-period, div2, reload 3 then 1
        @(negedge clk);
        frac_sel = 1'b0; div3_sel = 1'b0; reload = 13'd3;
        @(negedge clk);
        run = 1'b1;
        for (int idx = 1; idx <= 16; idx++) begin
            @(negedge clk);
            if (idx == 3) reload = 13'd1;
            check("R7 reload change os_tick", os_tick,
                  (idx == 8 || idx == 12 || idx == 16) ? 1 : 0);
        end
        stop_idle(2);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule